// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block does lane-wise integer addition and subtraction on two 32-bit operands. Each operand is split into two 16-bit halfword lanes or four 8-bit byte lanes. The operation select sets the lane split. It also chooses between straight lane-to-lane add or subtract and two exchange forms. In an exchange form the halfwords of operand B trade places, one halfword lane adds and the other subtracts.

The arithmetic-mode select chooses how each lane result is formed. Wrapping keeps the low lane bits. Saturating clamps the result to the lane's range. Halving keeps the sum or difference shifted right by one, with no overflow. Each of the three kinds has a signed and an unsigned form, so there are 36 legal mode and operation pairs. In the wrapping modes a 4-bit greater-or-equal vector comes out beside the result. An execution pipeline uses the unit as a packed-arithmetic slice. A parameter selects whether the result is registered (the default) or combinational.

Top module: `simd_addsub`

## Requirements
- R1: While `rst_n` is low, `result` and `ge` are zero.
- R2: With the output register present, `result` and `ge` show the value for the inputs present at the previous rising clock edge when `out_en` was high. While `out_en` is low they hold their value.
- R3: Halfword operations: `op_sel`=0 adds and `op_sel`=3 subtracts. Each halfword lane `result[16i+15:16i]` uses only `a[16i+15:16i]` and `b[16i+15:16i]`, and no carry or borrow crosses bit 16.
- R4: Exchange operations: with `op_sel`=1, `result[31:16]` = `a[31:16]` + `b[15:0]` and `result[15:0]` = `a[15:0]` - `b[31:16]`. With `op_sel`=2, `result[31:16]` = `a[31:16]` - `b[15:0]` and `result[15:0]` = `a[15:0]` + `b[31:16]`.
- R5: Byte operations: `op_sel`=4 adds and `op_sel`=5 subtracts. Each of the four bytes `result[8i+7:8i]` is computed independently from the matching bytes of `a` and `b`.
- R6: Wrapping modes (`mode_sel`=0 signed, 4 unsigned): each lane result is the exact sum or difference modulo 2^n, where n is the lane width.
- R7: Signed saturating mode (`mode_sel`=1): each lane result is the exact signed sum or difference clamped to [-2^(n-1), 2^(n-1)-1].
- R8: Unsigned saturating mode (`mode_sel`=5): each lane result is the exact unsigned sum or difference clamped to [0, 2^n-1], so a subtract that underflows yields 0.
- R9: Halving modes (`mode_sel`=2 signed, 6 unsigned): each lane result is the exact sum or difference (signed or unsigned operands) divided by two with rounding toward minus infinity, taken modulo 2^n.
- R10: In the wrapping modes, a lane's GE flag is 1 when its signed result is >= 0. For unsigned lanes it is 1 when an add carries out or a subtract does not borrow. A byte lane i drives `ge[i]`, and halfword lane i drives both `ge[2i+1]` and `ge[2i]`. In all other modes `ge` is 0.
- R11: Reserved encodings (`mode_sel` 3 or 7, `op_sel` 6 or 7) give a zero `result` and a zero `ge`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| out_en | input | 1 | Clock enable for the output register |
| mode_sel | input | 3 | Arithmetic mode: bit 2 unsigned, bits 1:0 wrap/saturate/halve |
| op_sel | input | 3 | Operation and lane-split select |
| a | input | 32 | First packed operand |
| b | input | 32 | Second packed operand |
| result | output | 32 | Packed lane results |
| ge | output | 4 | Per-byte greater-or-equal flags |

## Verification
The default configuration has one register between the inputs and both outputs. So `result` and `ge` are due at the first rising edge after a stimulus. The bench changes inputs on a falling edge and compares on the next falling edge, which is half a period after that rising edge. The hold check leaves `out_en` low across one rising edge with new operands and compares on the following falling edge. The reset check samples while reset is low, after a rising edge with live inputs.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    KIND_WRAP  = 2'd0,
    KIND_SAT   = 2'd1,
    KIND_HALVE = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    OP_ADD_H  = 3'd0,
    OP_XADD_H = 3'd1,
    OP_XSUB_H = 3'd2,
    OP_SUB_H  = 3'd3,
    OP_ADD_B  = 3'd4,
    OP_SUB_B  = 3'd5,
    OP_RSV6   = 3'd6,
    OP_RSV7   = 3'd7
  } op_e;

  function automatic kind_e mode_kind(input logic [2:0] m);
    return kind_e'(m[1:0]);
  endfunction

  function automatic logic mode_unsigned(input logic [2:0] m);
    return m[2];
  endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         uns,
  input  kind_e        kind,
  output logic [W-1:0] res,
  output logic         ge
);

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ae, be, sx;
  logic       ovf_s;

  always_comb begin
    ae    = uns ? {1'b0, a} : {a[W-1], a};
    be    = uns ? {1'b0, b} : {b[W-1], b};
    sx    = sub ? (ae - be) : (ae + be);
    ovf_s = sx[W] ^ sx[W-1];
  end

  always_comb begin
    unique case (kind)
      KIND_WRAP:  res = sx[W-1:0];
      KIND_SAT: begin
        if (uns) begin
          if (sx[W]) res = sub ? '0 : '1;
          else       res = sx[W-1:0];
        end else begin
          if (ovf_s) res = sx[W] ? SMIN : SMAX;
          else       res = sx[W-1:0];
        end
      end
      KIND_HALVE: res = sx[W:1];
      default:    res = '0;
    endcase
  end

  always_comb begin
    if (kind != KIND_WRAP) ge = 1'b0;
    else if (uns)          ge = sub ? ~sx[W] : sx[W];
    else                   ge = ~sx[W];
  end

  AST_USAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (uns && kind == KIND_SAT && sub && (a < b)) |-> (res == '0)); // R8

  AST_USAT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (uns && kind == KIND_SAT && !sub && ((({1'b0, a} + {1'b0, b}) >> W) != '0)) |-> (res == '1)); // R8

  AST_WRAP_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_WRAP && !sub) |-> (res == W'(a + b))); // R6

endmodule

// File: rtl/simd_route.sv
module simd_route
  import simd_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HW    = DATA_W / 2
) (
  input  logic [2:0]          op_sel,
  input  logic [DATA_W-1:0]   b,
  output logic [1:0][HW-1:0]  b_half,
  output logic [1:0]          sub_half,
  output logic                is_byte,
  output logic                sub_byte,
  output logic                op_ok
);

  logic [HW-1:0] b_hi, b_lo;

  always_comb begin
    b_hi     = b[DATA_W-1:HW];
    b_lo     = b[HW-1:0];
    b_half   = {b_hi, b_lo};
    sub_half = 2'b00;
    is_byte  = 1'b0;
    sub_byte = 1'b0;
    op_ok    = 1'b1;
    unique case (op_e'(op_sel))
      OP_ADD_H:  sub_half = 2'b00;
      OP_XADD_H: begin
        b_half   = {b_lo, b_hi};
        sub_half = 2'b01;
      end
      OP_XSUB_H: begin
        b_half   = {b_lo, b_hi};
        sub_half = 2'b10;
      end
      OP_SUB_H:  sub_half = 2'b11;
      OP_ADD_B:  is_byte  = 1'b1;
      OP_SUB_B: begin
        is_byte  = 1'b1;
        sub_byte = 1'b1;
      end
      default:   op_ok    = 1'b0;
    endcase
  end

endmodule

// File: rtl/simd_outreg.sv
module simd_outreg #(
  parameter int  DATA_W  = 32,
  parameter int  GE_W    = 4,
  parameter bit  OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_en,
  input  logic [DATA_W-1:0] res_d,
  input  logic [GE_W-1:0]   ge_d,
  output logic [DATA_W-1:0] res_q,
  output logic [GE_W-1:0]   ge_q
);

  generate
    if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] res_r, res_nxt;
      logic [GE_W-1:0]   ge_r, ge_nxt;

      always_comb begin
        res_nxt = res_r;
        ge_nxt  = ge_r;
        if (out_en) begin
          res_nxt = res_d;
          ge_nxt  = ge_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_r <= '0;
          ge_r  <= '0;
        end else begin
          res_r <= res_nxt;
          ge_r  <= ge_nxt;
        end
      end

      assign res_q = res_r;
      assign ge_q  = ge_r;

      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> ($stable(res_r) && $stable(ge_r))); // R2
    end else begin : g_comb
      assign res_q = res_d;
      assign ge_q  = ge_d;
    end
  endgenerate

endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                out_en,
  input  logic [2:0]          mode_sel,
  input  logic [2:0]          op_sel,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  output logic [DATA_W-1:0]   result,
  output logic [DATA_W/8-1:0] ge
);

  localparam int HW     = DATA_W / 2;
  localparam int BW     = DATA_W / 4;
  localparam int N_HALF = 2;
  localparam int N_BYTE = 4;
  localparam int GE_W   = N_BYTE;
  localparam int GE_PER_HALF = GE_W / N_HALF;

  kind_e                    kind;
  logic                     uns;
  logic                     mode_ok;
  logic [1:0][HW-1:0]       b_half;
  logic [1:0]               sub_half;
  logic                     is_byte, sub_byte, op_ok;
  logic [N_HALF-1:0][HW-1:0] half_res;
  logic [N_HALF-1:0]        half_ge;
  logic [N_BYTE-1:0][BW-1:0] byte_res;
  logic [N_BYTE-1:0]        byte_ge;
  logic [DATA_W-1:0]        res_d;
  logic [GE_W-1:0]          ge_d;
  logic [GE_W-1:0]          ge_half_x;

  always_comb begin
    kind    = mode_kind(mode_sel);
    uns     = mode_unsigned(mode_sel);
    mode_ok = (kind != KIND_RSVD);
  end

  simd_route #(.DATA_W(DATA_W)) u_route (
    .op_sel   (op_sel),
    .b        (b),
    .b_half   (b_half),
    .sub_half (sub_half),
    .is_byte  (is_byte),
    .sub_byte (sub_byte),
    .op_ok    (op_ok)
  );

  generate
    for (genvar h = 0; h < N_HALF; h++) begin : g_half
      simd_lane #(.W(HW)) u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (a[h*HW +: HW]),
        .b     (b_half[h]),
        .sub   (sub_half[h]),
        .uns   (uns),
        .kind  (kind),
        .res   (half_res[h]),
        .ge    (half_ge[h])
      );
      for (genvar g = 0; g < GE_PER_HALF; g++) begin : g_gex
        assign ge_half_x[h*GE_PER_HALF + g] = half_ge[h];
      end
    end
    for (genvar k = 0; k < N_BYTE; k++) begin : g_byte
      simd_lane #(.W(BW)) u_lane (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (a[k*BW +: BW]),
        .b     (b[k*BW +: BW]),
        .sub   (sub_byte),
        .uns   (uns),
        .kind  (kind),
        .res   (byte_res[k]),
        .ge    (byte_ge[k])
      );
    end
  endgenerate

  always_comb begin
    res_d = '0;
    ge_d  = '0;
    if (mode_ok && op_ok) begin
      res_d = is_byte ? byte_res : half_res;
      ge_d  = is_byte ? byte_ge  : ge_half_x;
    end
  end

  simd_outreg #(.DATA_W(DATA_W), .GE_W(GE_W), .OUT_REG(OUT_REG)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .out_en (out_en),
    .res_d  (res_d),
    .ge_d   (ge_d),
    .res_q  (result),
    .ge_q   (ge)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[1:0] == 2'b11 || op_sel[2:1] == 2'b11) |-> (res_d == '0 && ge_d == '0)); // R11

  AST_GE_WRAP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[1:0] != 2'b00) |-> (ge_d == '0)); // R10

endmodule

// File: tb/sim_simd_addsub.sv
module sim_simd_addsub;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        out_en;
  logic [2:0]  mode_sel, op_sel;
  logic [31:0] a, b;
  logic [31:0] result;
  logic [3:0]  ge;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  simd_addsub u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_en   (out_en),
    .mode_sel (mode_sel),
    .op_sel   (op_sel),
    .a        (a),
    .b        (b),
    .result   (result),
    .ge       (ge)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h (mode=%0d op=%0d a=%08h b=%08h)",
               tag, act, exp, mode_sel, op_sel, a, b);
    end
  endtask

  task automatic model(input logic [2:0] m, input logic [2:0] o,
                       input logic [31:0] av32, input logic [31:0] bv32,
                       output logic [31:0] r, output logic [3:0] g);
    int n, lanes;
    bit un;
    longint mask;
    r = '0;
    g = '0;
    if (m[1:0] == 2'b11 || o >= 3'd6) return;
    n     = (o >= 3'd4) ? 8 : 16;
    lanes = 32 / n;
    un    = m[2];
    mask  = (64'sd1 <<< n) - 1;
    for (int i = 0; i < lanes; i++) begin
      longint av, bv, t, rv;
      bit sb, gb;
      av = (longint'(av32) >>> (i*n)) & mask;
      if (o == 3'd1 || o == 3'd2) bv = (i == 1) ? longint'(bv32[15:0]) : longint'(bv32[31:16]);
      else                        bv = (longint'(bv32) >>> (i*n)) & mask;
      sb = (o == 3'd3) || (o == 3'd5) || (o == 3'd1 && i == 0) || (o == 3'd2 && i == 1);
      if (!un) begin
        if (av >= (64'sd1 <<< (n-1))) av = av - (64'sd1 <<< n);
        if (bv >= (64'sd1 <<< (n-1))) bv = bv - (64'sd1 <<< n);
      end
      t = sb ? av - bv : av + bv;
      case (m[1:0])
        2'd0: rv = t;
        2'd1: begin
          rv = t;
          if (un) begin
            if (rv < 0) rv = 0;
            if (rv > mask) rv = mask;
          end else begin
            if (rv < -(64'sd1 <<< (n-1))) rv = -(64'sd1 <<< (n-1));
            if (rv > (64'sd1 <<< (n-1)) - 1) rv = (64'sd1 <<< (n-1)) - 1;
          end
        end
        default: rv = t >>> 1;
      endcase
      r = r | (32'(rv & mask) << (i*n));
      if (m[1:0] == 2'd0) begin
        gb = un ? (sb ? (t >= 0) : (t > mask)) : (t >= 0);
        if (n == 8) g[i] = gb;
        else begin
          g[2*i]   = gb;
          g[2*i+1] = gb;
        end
      end
    end
  endtask

  function automatic logic [31:0] corner_a(input int k);
    case (k)
      0: return 32'h7FFF7FFF;
      1: return 32'h80008000;
      2: return 32'hFFFFFFFF;
      3: return 32'h00000000;
      4: return 32'h7F7F7F7F;
      5: return 32'h80808080;
      6: return 32'h80000000;
      7: return 32'h12345678;
      8: return 32'h0000FFFF;
      default: return 32'h00010001;
    endcase
  endfunction

  function automatic logic [31:0] corner_b(input int k);
    case (k)
      0: return 32'h00010001;
      1: return 32'h00010001;
      2: return 32'h01010101;
      3: return 32'hFFFFFFFF;
      4: return 32'h01010101;
      5: return 32'h01010101;
      6: return 32'h7FFFFFFF;
      7: return 32'h9ABCDEF0;
      8: return 32'h00000001;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0, 3'd4: return "R6";
      3'd1:       return "R7";
      3'd5:       return "R8";
      3'd2, 3'd6: return "R9";
      default:    return "R11";
    endcase
  endfunction

  task automatic apply(input logic [2:0] m, input logic [2:0] o,
                       input logic [31:0] av, input logic [31:0] bv);
    @(negedge clk);
    mode_sel = m;
    op_sel   = o;
    a        = av;
    b        = bv;
    @(negedge clk);
  endtask

  task automatic sweep_one(input logic [2:0] m, input logic [2:0] o,
                           input logic [31:0] av, input logic [31:0] bv);
    logic [31:0] er;
    logic [3:0]  eg;
    string rt;
    apply(m, o, av, bv);
    model(m, o, av, bv, er, eg);
    rt = (o >= 3'd6) ? "R11" : mode_tag(m);
    check(rt, result, er);
    check((m[1:0] == 2'b11 || o >= 3'd6) ? "R11" : "R10", {28'd0, ge}, {28'd0, eg});
  endtask

  initial begin
    rst_n    = 1'b0;
    out_en   = 1'b1;
    mode_sel = 3'd0;
    op_sel   = 3'd0;
    a        = 32'h12345678;
    b        = 32'h11111111;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", result, 32'h0);
    check("R1", {28'd0, ge}, 32'h0);
    rst_n = 1'b1;

    // R3: no carry from the low halfword into the high one
    apply(3'd0, 3'd0, 32'h0000FFFF, 32'h00000001);
    check("R3", result, 32'h00000000);
    apply(3'd0, 3'd3, 32'h00010000, 32'h00000001);
    check("R3", result, 32'h0001FFFF);
    // R4: exchange forms
    apply(3'd0, 3'd1, 32'h00050005, 32'h00030001);
    check("R4", result, 32'h00060002);
    apply(3'd0, 3'd2, 32'h00050005, 32'h00030001);
    check("R4", result, 32'h00040008);
    // R5: independent bytes
    apply(3'd0, 3'd4, 32'h000000FF, 32'h00000001);
    check("R5", result, 32'h00000000);
    apply(3'd0, 3'd5, 32'h00000000, 32'h00000001);
    check("R5", result, 32'h000000FF);

    // R2: hold while the enable is low
    apply(3'd4, 3'd0, 32'h00020003, 32'h00040005);
    check("R2", result, 32'h00060008);
    @(negedge clk);
    out_en = 1'b0;
    a      = 32'hDEADBEEF;
    op_sel = 3'd4;
    @(negedge clk);
    check("R2", result, 32'h00060008);
    out_en = 1'b1;

    for (int m = 0; m < 8; m++) begin
      for (int o = 0; o < 8; o++) begin
        for (int k = 0; k < 10; k++)
          sweep_one(3'(m), 3'(o), corner_a(k), corner_b(k));
        for (int k = 0; k < 24; k++)
          sweep_one(3'(m), 3'(o), $urandom, $urandom);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule